// File: doc/BRIEF.md
# Quarter-Rate Edge-Vote Phase Detector

This block sits between the deserializer of a quarter-rate serial receiver and the digital loop filter of its clock-recovery loop. Each clock it takes a word of 8 data decisions and a word of 8 edge decisions. The edge samples fall between neighbouring data samples. Every neighbouring data pair that holds a transition casts one vote: the clock is either early or late, depending on which data bit the edge sample between them agrees with.

There is one pair per edge bit. The pair that joins the last data bit of one word to the first data bit of the next is formed with a bit that is held over from the previous cycle. All votes are reduced by majority to one decision per word. The decision is driven on three one-hot registered outputs: early, late and hold. The loop filter then turns that stream into phase steps.

Top module: `qr_edge_vote_pd`

## Requirements
- R1: For lane i from 0 to 6, the vote is formed from data bit i (earlier), edge bit i and data bit i+1 (later), all taken from the same input word. Bit 0 is the earliest bit in time.
- R2: A pair whose earlier and later data bits are equal casts no vote.
- R3: A pair with a transition whose edge bit equals the later data bit casts a late vote.
- R4: A pair with a transition whose edge bit equals the earlier data bit casts an early vote.
- R5: The boundary pair is formed from data bit 7 and edge bit 7 of the previous word, together with data bit 0 of the current word.
- R6: The boundary pair casts no vote for the first word accepted after reset, whatever was applied before or during reset.
- R7: When early votes outnumber late votes the decision is early. When late votes outnumber early votes the decision is late.
- R8: A tie, including the case of no votes at all, gives the decision hold.
- R9: Exactly one of early_o, late_o and hold_o is high. The decision for a word appears after the clock edge that samples the word and stays until the next edge.
- R10: A synchronous active-high reset drives the outputs to hold and clears the held-over boundary bits. Words applied while reset is high have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | LANES (8) | Data decisions, bit 0 earliest |
| edge_i | input | LANES (8) | Edge decisions, bit i between data bits i and i+1 |
| early_o | output | 1 | Registered decision: sampling clock is early |
| late_o | output | 1 | Registered decision: sampling clock is late |
| hold_o | output | 1 | Registered decision: no net correction |

## Verification
The boundary vote from the held-over bits and the in-word lane votes are counted in the same cycle. The stimulus is ordered so that the boundary vote alone decides the result, breaks a tie, or ties a result that would otherwise go one way. It also includes words where the boundary pair has no transition, so that only the in-word votes count. Each word's edge bits are forced to the early or late value lane by lane. The expected decision follows from counting the transitions of the current word and of the previous word's last bit. The bench also checks that the reset clears the held-over bit, so a word applied during reset cannot reach the first vote after reset.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [1:0] {
    PD_HOLD  = 2'b00,
    PD_EARLY = 2'b01,
    PD_LATE  = 2'b10
  } pd_dec_e;

  function automatic pd_dec_e pd_majority(input int unsigned n_early,
                                          input int unsigned n_late);
    if (n_early > n_late)      return PD_EARLY;
    else if (n_late > n_early) return PD_LATE;
    else                       return PD_HOLD;
  endfunction

endpackage

// File: rtl/pd_pair_vote.sv
module pd_pair_vote (
  input  logic en,
  input  logic d_first,
  input  logic edge_s,
  input  logic d_second,
  output logic early_o,
  output logic late_o
);

  logic trans;

  always_comb begin
    trans   = en && (d_first != d_second);
    // R3: edge agrees with the later bit; R4: edge agrees with the earlier bit
    late_o  = trans && (edge_s == d_second);
    early_o = trans && (edge_s == d_first);
  end

  // R2: a pair never casts two votes
  always_comb begin
    a_r2_single_vote: assert ($onehot0({early_o, late_o}));
  end

endmodule

// File: rtl/pd_tally.sv
module pd_tally #(
  parameter int LANES = 8,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] early_v,
  input  logic [LANES-1:0] late_v,
  output logic [CW-1:0]    n_early,
  output logic [CW-1:0]    n_late
);

  always_comb begin
    n_early = '0;
    n_late  = '0;
    for (int i = 0; i < LANES; i++) begin
      n_early = n_early + CW'(early_v[i]);
      n_late  = n_late  + CW'(late_v[i]);
    end
  end

  // R2: total votes never exceed the number of pairs
  always_comb begin
    a_r2_vote_bound: assert ((32'(n_early) + 32'(n_late)) <= 32'(LANES));
  end

endmodule

// File: rtl/pd_decide.sv
module pd_decide #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] n_early,
  input  logic [CW-1:0] n_late,
  output logic          early_o,
  output logic          late_o,
  output logic          hold_o
);
  import pd_pkg::*;

  pd_dec_e dec_q;

  always_ff @(posedge clk) begin
    if (rst) dec_q <= PD_HOLD;
    else     dec_q <= pd_majority(32'(n_early), 32'(n_late));
  end

  always_comb begin
    early_o = (dec_q == PD_EARLY);
    late_o  = (dec_q == PD_LATE);
    hold_o  = (dec_q == PD_HOLD);
  end

  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones({early_o, late_o, hold_o}) == 1);

  a_r10_reset_hold: assert property (@(posedge clk)
    rst |=> (hold_o && !early_o && !late_o));

  a_r7_early_wins: assert property (@(posedge clk) disable iff (rst)
    (n_early > n_late) |=> early_o);

  a_r7_late_wins: assert property (@(posedge clk) disable iff (rst)
    (n_late > n_early) |=> late_o);

  a_r8_tie_holds: assert property (@(posedge clk) disable iff (rst)
    (n_early == n_late) |=> hold_o);

endmodule

// File: rtl/qr_edge_vote_pd.sv
module qr_edge_vote_pd #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] data_i,
  input  logic [LANES-1:0] edge_i,
  output logic             early_o,
  output logic             late_o,
  output logic             hold_o
);

  localparam int CW = $clog2(LANES + 1);

  logic [LANES-1:0] early_v, late_v;
  logic [CW-1:0]    n_early, n_late;
  logic             carry_d, carry_e, carry_ok;

  // R1: in-word pairs
  for (genvar i = 0; i < LANES - 1; i++) begin : g_lane
    pd_pair_vote u_pair (
      .en      (1'b1),
      .d_first (data_i[i]),
      .edge_s  (edge_i[i]),
      .d_second(data_i[i+1]),
      .early_o (early_v[i]),
      .late_o  (late_v[i])
    );
  end

  // R5: pair spanning the word boundary uses held-over bits
  pd_pair_vote u_wrap (
    .en      (carry_ok),
    .d_first (carry_d),
    .edge_s  (carry_e),
    .d_second(data_i[0]),
    .early_o (early_v[LANES-1]),
    .late_o  (late_v[LANES-1])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_d  <= 1'b0;
      carry_e  <= 1'b0;
      carry_ok <= 1'b0;
    end else begin
      carry_d  <= data_i[LANES-1];
      carry_e  <= edge_i[LANES-1];
      carry_ok <= 1'b1;
    end
  end

  // R6: no boundary vote in the first word after reset
  a_r6_no_wrap_after_reset: assert property (@(posedge clk)
    rst |=> (!early_v[LANES-1] && !late_v[LANES-1]));

  // R5: boundary vote follows the word that was sampled one edge earlier
  a_r5_wrap_late: assert property (@(posedge clk) disable iff (rst)
    (data_i[LANES-1] != edge_i[LANES-1]) |=>
      (($past(rst) || (data_i[0] == carry_d)) || late_v[LANES-1]));

  pd_tally #(.LANES(LANES)) u_tally (
    .early_v(early_v),
    .late_v (late_v),
    .n_early(n_early),
    .n_late (n_late)
  );

  pd_decide #(.CW(CW)) u_decide (
    .clk    (clk),
    .rst    (rst),
    .n_early(n_early),
    .n_late (n_late),
    .early_o(early_o),
    .late_o (late_o),
    .hold_o (hold_o)
  );

endmodule

// File: tb/qr_edge_vote_pd_tb_top.sv
module qr_edge_vote_pd_tb_top;

  localparam int CLK_P = 10;
  localparam int NV    = 16;
  localparam logic [1:0] XH = 2'd0, XE = 2'd1, XL = 2'd2;

  // {data, early_mask, expected}; mask bit i = 1 forces edge bit i to the early value
  localparam logic [17:0] VEC [NV] = '{
    {8'h00, 8'h00, XH},  // R2 no transitions
    {8'h00, 8'h00, XH},  // R5 boundary without transition
    {8'h55, 8'h00, XL},  // R3 all 8 late incl. boundary
    {8'h55, 8'hFF, XE},  // R4 7 early vs boundary late
    {8'h55, 8'h0F, XE},  // R5 boundary early: 5 vs 3
    {8'h55, 8'h07, XL},  // 3 early vs 5 late
    {8'h55, 8'h0F, XH},  // R8 4 vs 4 tie via boundary
    {8'h0F, 8'h08, XH},  // R8 boundary late ties lane 3 early
    {8'h0F, 8'h00, XL},  // lane 3 and boundary late
    {8'hF0, 8'h08, XE},  // R1 lane 3 alone
    {8'h0F, 8'h80, XL},  // lane 3 late, mask on idle lane ignored
    {8'hFE, 8'h01, XE},  // R1 lane 0 early
    {8'h01, 8'h00, XL},  // lane 0 late
    {8'h80, 8'h40, XE},  // R1 lane 6 early
    {8'h00, 8'h80, XL},  // R5 boundary alone late
    {8'hFF, 8'h80, XE}   // R5 boundary alone early
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] data_i = '0, edge_i = '0;
  logic early_o, late_o, hold_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  qr_edge_vote_pd #(.LANES(8)) dut_i (
    .clk(clk), .rst(rst), .data_i(data_i), .edge_i(edge_i),
    .early_o(early_o), .late_o(late_o), .hold_o(hold_o)
  );

  function automatic logic [7:0] mk_edge(input logic [7:0] d, input logic [7:0] m);
    logic [7:0] e;
    for (int i = 0; i < 7; i++) e[i] = m[i] ? d[i] : d[i+1];
    e[7] = m[7] ? d[7] : ~d[7];
    return e;
  endfunction

  task automatic check(input logic [1:0] exp, input string req);
    logic [2:0] got, want;
    got  = {late_o, early_o, hold_o};
    want = (exp == XE) ? 3'b010 : (exp == XL) ? 3'b100 : 3'b001;
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: {late,early,hold} actual %b expected %b", req, got, want);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [1:0] prev;
    repeat (3) @(negedge clk);
    check(XH, "R10 reset state");
    rst = 1'b0;
    prev = XH;
    for (int k = 0; k < NV; k++) begin
      data_i = VEC[k][17:10];
      edge_i = mk_edge(VEC[k][17:10], VEC[k][9:2]);
      check(prev, "R9 no change before edge");
      @(posedge clk); @(negedge clk);
      check(VEC[k][1:0], (VEC[k][1:0] == XH) ? "R8 table" : "R7 table");
      prev = VEC[k][1:0];
    end
    // words with no votes
    data_i = 8'hFF; edge_i = mk_edge(8'hFF, 8'h00);
    @(posedge clk); @(negedge clk);
    check(XH, "R2 constant word");
    // reset with a voting word applied: ignored, boundary cleared
    rst = 1'b1; data_i = 8'hAA; edge_i = mk_edge(8'hAA, 8'h00);
    @(posedge clk); @(negedge clk);
    check(XH, "R10 word during reset ignored");
    @(posedge clk); @(negedge clk);
    check(XH, "R10 reset held");
    rst = 1'b0; data_i = 8'h00; edge_i = 8'h00;
    @(posedge clk); @(negedge clk);
    check(XH, "R6 first word after reset");
    data_i = 8'h00; edge_i = 8'h00;
    @(posedge clk); @(negedge clk);
    check(XH, "R2 idle after reset");
    // boundary after reset works again: previous d7=0,e7=0; d0=1 -> early
    data_i = 8'h01; edge_i = 8'h00;  // lane 0: d0=1,d1=0,e0=0 -> late
    @(posedge clk); @(negedge clk);
    check(XH, "R5 boundary early ties lane late");
    done = 1;
    finish_run();
  end

endmodule